// File: doc/BRIEF.md
# Floating-Point Move Decoder with Size Mode

This block sits in the decode stage of a 16-bit-instruction RISC core. It recognises the floating-point move, load and store instructions and turns each one into a small set of control outputs:

- a memory request: address, read or write, and a 32-bit or 64-bit transfer;
- floating-point register read and write selects, each with a bank bit;
- a writeback for the general base register;
- the updated floating-point status/control word;
- an illegal-instruction flag.

The register file, the memory and the arithmetic datapath live elsewhere. The caller supplies the instruction word, the values of the general registers named by the n field, the m field and R0, and the current status/control word.

A size-mode bit in the status/control word gives the same opcodes a second meaning. With the bit set, one 32-bit register becomes an even-aligned register pair that moves as 64 bits. Bit 0 of the register field then picks the current bank or the extended bank. The auto-increment and auto-decrement step grows from 4 to 8. Two opcodes flip the bank-select bit and the size-mode bit. The precision-conversion opcodes are screened for illegal use.

Instructions arrive on a valid/ready stream, and results leave on a second valid/ready stream one cycle later. The input is accepted whenever the output register is empty or is being drained in the same cycle: `in_ready = !out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output holds its value and no new instruction is taken.

Top module: `fpmov_decoder`

## Requirements
- R1: A word of the form 0xFnmC is a register-to-register move. It makes no memory request. It reads FP register m and writes FP register n. `xfer_wide` equals the size-mode bit, which is bit 20 of `csr_in`.
- R2: Low nibble 0x8 is a load from address Rm. Low nibble 0xA is a store to address Rn. A load sets `fp_wr_en` on field n. A store sets `fp_rd_en` on field m. For every memory form `xfer_wide` follows the size-mode bit and `mem_write` is 1 only for stores.
- R3: Low nibble 0x9 is a post-increment load. It reads from address Rm. It writes Rm plus 8 (size mode) or plus 4 back to general register m.
- R4: Low nibble 0xB is a pre-decrement store. Both the store address and the value written back to general register n are Rn minus 8 (size mode) or minus 4.
- R5: Low nibbles 0x6 (load) and 0x7 (store) are indexed forms. They use the address R0 + Rm for the load and R0 + Rn for the store, with no base writeback.
- R6: With size mode clear, a register index equals its 4-bit field and the bank bit is 0. With size mode set, the index is the field with bit 0 forced to 0, and the bank bit equals field bit 0.
- R7: Word 0xFBFD inverts bit 21 (bank select) of the status/control word, and word 0xF3FD inverts bit 20 (size mode). Either one sets `csr_we`, and no other bit changes.
- R8: Words 0xFnBD and 0xFnAD raise `illegal` when bit 19 (precision) of `csr_in` is 0 or n is odd. Otherwise they produce no request, writeback or status write.
- R9: A word with top nibble 0xF that matches none of the above raises `illegal`. Such a word makes no memory request, no register select, no base writeback and no status write. Every unused address, index and value output is 0.
- R10: A word whose top nibble is not 0xF produces all-zero control outputs, with `illegal` low.
- R11: Every result appears on the cycle after acceptance. Results are held unchanged while stalled, with `in_ready` low, and none is dropped or duplicated.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.
- R13: `csr_out` equals `csr_in` for every instruction except the two toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle if valid |
| insn | input | 16 | Instruction word |
| rn_val | input | AW | Value of general register named by bits 11:8 |
| rm_val | input | AW | Value of general register named by bits 7:4 |
| r0_val | input | AW | Value of general register 0 |
| csr_in | input | CW | Current FP status/control word |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Consumer takes the result |
| mem_req | output | 1 | Memory access required |
| mem_write | output | 1 | 1 = store, 0 = load |
| xfer_wide | output | 1 | 64-bit pair transfer |
| mem_addr | output | AW | Access address |
| fp_rd_en | output | 1 | FP register read |
| fp_rd_idx | output | 4 | FP read index |
| fp_rd_xbank | output | 1 | FP read from extended bank |
| fp_wr_en | output | 1 | FP register write |
| fp_wr_idx | output | 4 | FP write index |
| fp_wr_xbank | output | 1 | FP write to extended bank |
| base_wb_en | output | 1 | General base register writeback |
| base_wb_idx | output | 4 | General register to write back |
| base_wb_val | output | AW | Writeback value |
| csr_we | output | 1 | Status/control word changed |
| csr_out | output | CW | New status/control word |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
Embedded assertions watch several properties on every cycle:
- a stalled result stays frozen;
- an illegal result carries no side effects;
- the post-increment writeback exceeds the access address by exactly the step that matches the transfer width;
- the pre-decrement writeback equals the store address;
- a toggle flips exactly one status bit;
- the transfer width tracks the size-mode bit;
- wide register selects are even.

Only the bench scenarios show the rest:
- the exact decoding of each opcode nibble in both size modes;
- the bank bit taken from odd fields;
- the conversion legality matrix over precision and n parity;
- the rejection of unmatched 0xF words;
- the pass-through of non-FP words;
- in-order, loss-free delivery under irregular back-pressure.

// File: rtl/fpmov_pkg.sv
package fpmov_pkg;

  typedef enum logic [3:0] {
    K_NONE,
    K_BAD,
    K_RR,
    K_LD,
    K_ST,
    K_LDINC,
    K_STDEC,
    K_LDX,
    K_STX,
    K_TGL_FR,
    K_TGL_SZ,
    K_CNV
  } fpmov_kind_e;

  function automatic logic kind_is_load(input fpmov_kind_e k);
    return (k == K_LD) || (k == K_LDINC) || (k == K_LDX);
  endfunction

  function automatic logic kind_is_store(input fpmov_kind_e k);
    return (k == K_ST) || (k == K_STDEC) || (k == K_STX);
  endfunction

  function automatic logic kind_is_toggle(input fpmov_kind_e k);
    return (k == K_TGL_FR) || (k == K_TGL_SZ);
  endfunction

endpackage

// File: rtl/fpmov_classify.sv
module fpmov_classify
  import fpmov_pkg::*;
#(
  parameter int IW = 16,
  parameter int FW = 4
) (
  input  logic [IW-1:0] insn,
  input  logic          pr_mode,
  output fpmov_kind_e   kind,
  output logic [FW-1:0] fld_n,
  output logic [FW-1:0] fld_m,
  output logic          illegal
);

  localparam logic [3:0] FP_GROUP = 4'hF;
  localparam logic [7:0] LOW_TGL  = 8'hFD;
  localparam logic [7:0] LOW_CVA  = 8'hBD;
  localparam logic [7:0] LOW_CVB  = 8'hAD;
  localparam logic [FW-1:0] N_FR  = FW'(4'hB);
  localparam logic [FW-1:0] N_SZ  = FW'(4'h3);

  assign fld_n = insn[8 +: FW];
  assign fld_m = insn[4 +: FW];

  always_comb begin
    kind = K_NONE;
    if (insn[IW-1 -: 4] == FP_GROUP) begin
      case (insn[3:0])
        4'hC:    kind = K_RR;
        4'h8:    kind = K_LD;
        4'hA:    kind = K_ST;
        4'h9:    kind = K_LDINC;
        4'hB:    kind = K_STDEC;
        4'h6:    kind = K_LDX;
        4'h7:    kind = K_STX;
        4'hD: begin
          if (insn[7:0] == LOW_TGL) begin
            if (fld_n == N_FR)      kind = K_TGL_FR;
            else if (fld_n == N_SZ) kind = K_TGL_SZ;
            else                    kind = K_BAD;
          end else if (insn[7:0] == LOW_CVA || insn[7:0] == LOW_CVB) begin
            kind = K_CNV;
          end else begin
            kind = K_BAD;
          end
        end
        default: kind = K_BAD;
      endcase
    end
  end

  assign illegal = (kind == K_BAD) || ((kind == K_CNV) && (!pr_mode || fld_n[0]));

endmodule

// File: rtl/fpmov_regmap.sv
module fpmov_regmap #(
  parameter int FW = 4
) (
  input  logic [FW-1:0] fld,
  input  logic          pair_mode,
  output logic [FW-1:0] idx,
  output logic          xbank
);

  assign idx   = pair_mode ? {fld[FW-1:1], 1'b0} : fld;
  assign xbank = pair_mode & fld[0];

endmodule

// File: rtl/fpmov_agu.sv
module fpmov_agu
  import fpmov_pkg::*;
#(
  parameter int AW     = 32,
  parameter int STEP_S = 4
) (
  input  fpmov_kind_e   kind,
  input  logic          wide,
  input  logic [AW-1:0] rn_val,
  input  logic [AW-1:0] rm_val,
  input  logic [AW-1:0] r0_val,
  output logic          mem_req,
  output logic          mem_write,
  output logic [AW-1:0] addr,
  output logic          wb_en,
  output logic          wb_on_m,
  output logic [AW-1:0] wb_val
);

  localparam logic [AW-1:0] STEP_ONE = AW'(STEP_S);
  localparam logic [AW-1:0] STEP_TWO = AW'(2 * STEP_S);

  logic [AW-1:0] step;
  logic [AW-1:0] rn_dec;

  assign step   = wide ? STEP_TWO : STEP_ONE;
  assign rn_dec = rn_val - step;

  assign mem_req   = kind_is_load(kind) || kind_is_store(kind);
  assign mem_write = kind_is_store(kind);

  always_comb begin
    addr    = '0;
    wb_en   = 1'b0;
    wb_on_m = 1'b0;
    wb_val  = '0;
    case (kind)
      K_LD:  addr = rm_val;
      K_ST:  addr = rn_val;
      K_LDINC: begin
        addr    = rm_val;
        wb_en   = 1'b1;
        wb_on_m = 1'b1;
        wb_val  = rm_val + step;
      end
      K_STDEC: begin
        addr   = rn_dec;
        wb_en  = 1'b1;
        wb_val = rn_dec;
      end
      K_LDX: addr = r0_val + rm_val;
      K_STX: addr = r0_val + rn_val;
      default: ;
    endcase
  end

endmodule

// File: rtl/fpmov_decoder.sv
module fpmov_decoder
  import fpmov_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CW     = 32,
  parameter int PR_BIT = 19,
  parameter int SZ_BIT = 20,
  parameter int FR_BIT = 21,
  parameter int STEP_S = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [15:0]   insn,
  input  logic [AW-1:0] rn_val,
  input  logic [AW-1:0] rm_val,
  input  logic [AW-1:0] r0_val,
  input  logic [CW-1:0] csr_in,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          mem_req,
  output logic          mem_write,
  output logic          xfer_wide,
  output logic [AW-1:0] mem_addr,
  output logic          fp_rd_en,
  output logic [3:0]    fp_rd_idx,
  output logic          fp_rd_xbank,
  output logic          fp_wr_en,
  output logic [3:0]    fp_wr_idx,
  output logic          fp_wr_xbank,
  output logic          base_wb_en,
  output logic [3:0]    base_wb_idx,
  output logic [AW-1:0] base_wb_val,
  output logic          csr_we,
  output logic [CW-1:0] csr_out,
  output logic          illegal
);

  localparam int FW      = 4;
  localparam int NFIELDS = 2;
  localparam int PW      = 10 + 3 * FW + 2 * AW + CW;
  localparam logic [CW-1:0] MASK_FR = CW'(1) << FR_BIT;
  localparam logic [CW-1:0] MASK_SZ = CW'(1) << SZ_BIT;
  localparam logic [AW-1:0] STEP_ONE = AW'(STEP_S);
  localparam logic [AW-1:0] STEP_TWO = AW'(2 * STEP_S);

  fpmov_kind_e   kind;
  logic [FW-1:0] fld_n, fld_m;
  logic          ill_d;
  logic          sz_mode;

  assign sz_mode = csr_in[SZ_BIT];

  fpmov_classify #(.IW(16), .FW(FW)) u_cls (
    .insn    (insn),
    .pr_mode (csr_in[PR_BIT]),
    .kind    (kind),
    .fld_n   (fld_n),
    .fld_m   (fld_m),
    .illegal (ill_d)
  );

  // Field 0 = n (destination side), field 1 = m (source side)
  logic [FW-1:0] fld_sel [NFIELDS];
  logic [FW-1:0] map_idx [NFIELDS];
  logic          map_x   [NFIELDS];

  assign fld_sel[0] = fld_n;
  assign fld_sel[1] = fld_m;

  for (genvar g = 0; g < NFIELDS; g++) begin : g_map
    fpmov_regmap #(.FW(FW)) u_map (
      .fld       (fld_sel[g]),
      .pair_mode (sz_mode),
      .idx       (map_idx[g]),
      .xbank     (map_x[g])
    );
  end

  logic          uses_fp;
  logic          wide_d;
  logic          req_d, wr_d;
  logic [AW-1:0] addr_d;
  logic          wb_en_d, wb_on_m;
  logic [AW-1:0] wb_val_d;

  assign uses_fp = (kind == K_RR) || kind_is_load(kind) || kind_is_store(kind);
  assign wide_d  = uses_fp & sz_mode;

  fpmov_agu #(.AW(AW), .STEP_S(STEP_S)) u_agu (
    .kind      (kind),
    .wide      (wide_d),
    .rn_val    (rn_val),
    .rm_val    (rm_val),
    .r0_val    (r0_val),
    .mem_req   (req_d),
    .mem_write (wr_d),
    .addr      (addr_d),
    .wb_en     (wb_en_d),
    .wb_on_m   (wb_on_m),
    .wb_val    (wb_val_d)
  );

  logic          rd_en_d, wr_en_d;
  logic [FW-1:0] rd_idx_d, wr_idx_d, wb_idx_d;
  logic          rd_x_d, wr_x_d;
  logic          csr_we_d;
  logic [CW-1:0] csr_d;

  always_comb begin
    rd_en_d  = (kind == K_RR) || kind_is_store(kind);
    wr_en_d  = (kind == K_RR) || kind_is_load(kind);
    rd_idx_d = rd_en_d ? map_idx[1] : '0;
    rd_x_d   = rd_en_d & map_x[1];
    wr_idx_d = wr_en_d ? map_idx[0] : '0;
    wr_x_d   = wr_en_d & map_x[0];
    wb_idx_d = wb_en_d ? (wb_on_m ? fld_m : fld_n) : '0;
    csr_we_d = kind_is_toggle(kind);
    csr_d    = csr_in;
    if (kind == K_TGL_FR) csr_d = csr_in ^ MASK_FR;
    if (kind == K_TGL_SZ) csr_d = csr_in ^ MASK_SZ;
  end

  logic [PW-1:0] pay_d, pay_q;

  assign pay_d = {req_d, wr_d, wide_d, addr_d,
                  rd_en_d, rd_idx_d, rd_x_d,
                  wr_en_d, wr_idx_d, wr_x_d,
                  wb_en_d, wb_idx_d, wb_val_d,
                  csr_we_d, csr_d, ill_d};

  assign {mem_req, mem_write, xfer_wide, mem_addr,
          fp_rd_en, fp_rd_idx, fp_rd_xbank,
          fp_wr_en, fp_wr_idx, fp_wr_xbank,
          base_wb_en, base_wb_idx, base_wb_val,
          csr_we, csr_out, illegal} = pay_q;

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      pay_q     <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) pay_q <= pay_d;
    end
  end

  logic in_fire;
  assign in_fire = in_valid && in_ready;

  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(pay_q)); // R11

  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && illegal |-> !mem_req && !base_wb_en && !csr_we && !fp_rd_en && !fp_wr_en); // R9

  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && base_wb_en && !mem_write |->
      (base_wb_val - mem_addr) == (xfer_wide ? STEP_TWO : STEP_ONE)); // R3

  AST_PREDEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && base_wb_en && mem_write |-> base_wb_val == mem_addr); // R4

  AST_TOGGLE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && kind_is_toggle(kind) |=> csr_we && $countones(csr_out ^ $past(csr_in)) == 1); // R7

  AST_WIDTH_FOLLOWS_SZ: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && (kind_is_load(kind) || kind_is_store(kind)) |=> xfer_wide == $past(csr_in[SZ_BIT])); // R2

  AST_PAIR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && xfer_wide |-> !fp_wr_idx[0] && !fp_rd_idx[0]); // R6

endmodule

// File: tb/fpmov_decoder_test.sv
`timescale 1ns/1ps
module fpmov_decoder_test;

  localparam int AW = 32;
  localparam int CW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [15:0]   insn = '0;
  logic [AW-1:0] rn_val = '0, rm_val = '0, r0_val = '0;
  logic [CW-1:0] csr_in = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic          mem_req, mem_write, xfer_wide;
  logic [AW-1:0] mem_addr;
  logic          fp_rd_en, fp_rd_xbank, fp_wr_en, fp_wr_xbank;
  logic [3:0]    fp_rd_idx, fp_wr_idx, base_wb_idx;
  logic          base_wb_en, csr_we, illegal;
  logic [AW-1:0] base_wb_val;
  logic [CW-1:0] csr_out;

  fpmov_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .rn_val(rn_val), .rm_val(rm_val), .r0_val(r0_val),
    .csr_in(csr_in), .out_valid(out_valid), .out_ready(out_ready),
    .mem_req(mem_req), .mem_write(mem_write), .xfer_wide(xfer_wide),
    .mem_addr(mem_addr), .fp_rd_en(fp_rd_en), .fp_rd_idx(fp_rd_idx),
    .fp_rd_xbank(fp_rd_xbank), .fp_wr_en(fp_wr_en), .fp_wr_idx(fp_wr_idx),
    .fp_wr_xbank(fp_wr_xbank), .base_wb_en(base_wb_en),
    .base_wb_idx(base_wb_idx), .base_wb_val(base_wb_val),
    .csr_we(csr_we), .csr_out(csr_out), .illegal(illegal)
  );

  typedef struct packed {
    logic          mem_req;
    logic          mem_write;
    logic          wide;
    logic [AW-1:0] addr;
    logic          rd_en;
    logic [3:0]    rd_idx;
    logic          rd_x;
    logic          wr_en;
    logic [3:0]    wr_idx;
    logic          wr_x;
    logic          wb_en;
    logic [3:0]    wb_idx;
    logic [AW-1:0] wb_val;
    logic          csr_we;
    logic [CW-1:0] csr;
    logic          ill;
  } res_t;

  typedef struct {
    res_t  r;
    string tag;
  } item_t;

  item_t sb[$];
  int    n_checks = 0;
  int    n_fails  = 0;
  bit    finished = 1'b0;

  function automatic res_t actual();
    res_t a;
    a = '{mem_req, mem_write, xfer_wide, mem_addr, fp_rd_en, fp_rd_idx, fp_rd_xbank,
          fp_wr_en, fp_wr_idx, fp_wr_xbank, base_wb_en, base_wb_idx, base_wb_val,
          csr_we, csr_out, illegal};
    return a;
  endfunction

  function automatic logic [4:0] slot(input logic [3:0] f, input logic sz);
    return sz ? {f[3:1], 1'b0, f[0]} : {f, 1'b0};
  endfunction

  // Behavioural model written from the requirements
  function automatic res_t model(input logic [15:0] i, input logic [31:0] rn, rm, r0, c);
    res_t e;
    logic sz, pr;
    logic [3:0] n, m;
    logic [31:0] st;
    e = '0;
    e.csr = c;
    sz = c[20];
    pr = c[19];
    n = i[11:8];
    m = i[7:4];
    st = sz ? 32'd8 : 32'd4;
    if (i[15:12] != 4'hF) return e;
    case (i[3:0])
      4'hC: begin
        e.wide = sz;
        e.rd_en = 1; {e.rd_idx, e.rd_x} = slot(m, sz);
        e.wr_en = 1; {e.wr_idx, e.wr_x} = slot(n, sz);
      end
      4'h8, 4'h9, 4'h6: begin
        e.mem_req = 1; e.wide = sz;
        e.wr_en = 1; {e.wr_idx, e.wr_x} = slot(n, sz);
        e.addr = (i[3:0] == 4'h6) ? r0 + rm : rm;
        if (i[3:0] == 4'h9) begin
          e.wb_en = 1; e.wb_idx = m; e.wb_val = rm + st;
        end
      end
      4'hA, 4'hB, 4'h7: begin
        e.mem_req = 1; e.mem_write = 1; e.wide = sz;
        e.rd_en = 1; {e.rd_idx, e.rd_x} = slot(m, sz);
        e.addr = (i[3:0] == 4'h7) ? r0 + rn : (i[3:0] == 4'hB) ? rn - st : rn;
        if (i[3:0] == 4'hB) begin
          e.wb_en = 1; e.wb_idx = n; e.wb_val = rn - st;
        end
      end
      4'hD: begin
        if (i[7:0] == 8'hFD && n == 4'hB) begin
          e.csr_we = 1; e.csr = c ^ 32'h0020_0000;
        end else if (i[7:0] == 8'hFD && n == 4'h3) begin
          e.csr_we = 1; e.csr = c ^ 32'h0010_0000;
        end else if (i[7:0] == 8'hBD || i[7:0] == 8'hAD) begin
          e.ill = !pr || n[0];
        end else begin
          e.ill = 1;
        end
      end
      default: e.ill = 1;
    endcase
    return e;
  endfunction

  function automatic string tag_of(input logic [15:0] i, input logic sz);
    if (i[15:12] != 4'hF) return "R10";
    case (i[3:0])
      4'hC:       return (sz && (i[8] || i[4])) ? "R6" : "R1";
      4'h8, 4'hA: return (sz && (i[8] || i[4])) ? "R6" : "R2";
      4'h9:       return "R3";
      4'hB:       return "R4";
      4'h6, 4'h7: return "R5";
      4'hD: begin
        if (i[7:0] == 8'hFD && (i[11:8] == 4'hB || i[11:8] == 4'h3)) return "R7";
        if (i[7:0] == 8'hBD || i[7:0] == 8'hAD) return "R8";
        return "R9";
      end
      default:    return "R9";
    endcase
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  // Driver: offers one instruction, pushes its expected result on acceptance
  task automatic send(input logic [15:0] i, input logic [31:0] c);
    item_t it;
    insn   = i;
    csr_in = c;
    rn_val = 32'h4000_0100 + {20'd0, i[11:8], 8'h10};
    rm_val = 32'h8000_0F00 + {20'd0, i[7:4], 8'h04};
    r0_val = 32'h0001_2340 + {28'd0, i[3:0]};
    in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) begin
        it.r   = model(i, rn_val, rm_val, r0_val, c);
        it.tag = (i == 16'hF3FD || i == 16'hFBFD || i[3:0] != 4'hD) ? tag_of(i, c[20]) :
                 tag_of(i, c[20]);
        sb.push_back(it);
        break;
      end
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // Back-pressure pattern
  int cyc = 0;
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      out_ready = ((cyc % 7) != 2) && ((cyc % 11) != 5) && ((cyc % 13) != 6);
    end
  end

  // Monitor / scoreboard
  bit   prev_stall = 1'b0;
  res_t held;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall) begin
          n_checks++;
          if (!out_valid || actual() != held) begin
            n_fails++;
            $display("FAIL R11 stalled output changed: act=%h exp=%h", actual(), held);
          end
        end
        if (out_valid && !out_ready) begin
          n_checks++;
          if (in_ready !== 1'b0) begin
            n_fails++;
            $display("FAIL R11 in_ready during stall: act=%b exp=0", in_ready);
          end
        end
        if (out_valid && out_ready) begin
          n_checks++;
          if (sb.size() == 0) begin
            n_fails++;
            $display("FAIL R11 unexpected result: act=%h exp=none", actual());
          end else begin
            item_t e;
            e = sb.pop_front();
            if (actual() !== e.r) begin
              n_fails++;
              $display("FAIL %s insn result: act=%h exp=%h", e.tag, actual(), e.r);
            end
          end
        end
        prev_stall = out_valid && !out_ready;
        held = actual();
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: act=running exp=done (%0d pending)", sb.size());
      finish_run();
    end
  end

  logic [3:0] np [4] = '{4'h2, 4'h3, 4'h0, 4'h9};
  logic [3:0] mp [4] = '{4'h5, 4'h6, 4'hF, 4'h8};

  initial begin
    int k;
    k = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++; // R12 reset state
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fails++;
      $display("FAIL R12 reset state: act=%b%b exp=01", out_valid, in_ready);
    end
    @(posedge clk);
    #1;
    for (int c = 0; c < 8; c++) begin
      logic [31:0] cw;
      cw = 32'h0000_0C01 | (32'(c) << 19);
      for (int lo = 0; lo < 16; lo++) begin
        for (int p = 0; p < 4; p++) begin
          send({4'hF, np[p], mp[p], 4'(lo)}, cw);
          k++;
          if (k % 9 == 0) begin
            @(posedge clk);
            #1;
          end
        end
      end
      // toggles R7, unmatched 0xFnFD R9
      send(16'hFBFD, cw);
      send(16'hF3FD, cw);
      send(16'hF5FD, cw);
      // conversions R8 with even and odd n
      send(16'hF2BD, cw);
      send(16'hF3BD, cw);
      send(16'hF4AD, cw);
      send(16'hF7AD, cw);
      // other 0xF..D words R9
      send(16'hF12D, cw);
      send(16'hF33D, cw);
      // non-FP words R10 and status pass-through R13
      send(16'h6123, cw);
      send(16'hE1FD, cw);
      send(16'h0000, cw);
    end
    while (sb.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    finished = 1'b1;
    finish_run();
  end

endmodule